// File: doc/BRIEF.md
# Slot Pack Address Sequencer

This block plays the device side of a removable memory pack that sits on a shared 8-bit slot bus. The host never sends an address. Instead, the pack keeps a local address counter. The host clears and steps that counter by placing codes on three control lines: output-enable, master-reset and clock. The host reads the byte at the current address by putting the read code on the lines while the pack's active-low select is asserted.

The byte store is a fixed, synthesizable table that holds its contents from reset onward. Its first locations form an identification header, which the host reads at log-on. Data locations follow the header. The bus pad ring is outside this block. The block presents the byte on `bus_q` together with a drive-enable `bus_drive`, and the pad turns `bus_drive` low into a released, high-impedance pin.

The control inputs are asynchronous to the system clock, so they pass through a parameterised synchronizer first. The CK line is edge-detected against a registered copy of itself, and the counter advances on both its rising and its falling transitions.

Top module: `slot_pack_seq`

## Requirements
- R1: After reset, `bus_drive` is 0 and `bus_q` is 0x00, and the address counter is 0, so a read issued without a prior clear returns the byte at address 0.
- R2: While `slot_sel_n` is 1, no control code has any effect: the counter keeps its value, CK transitions are not counted later, and `bus_drive` stays 0.
- R3: With select active and OE=0, MR=0, each transition of CK, rising or falling, increments the address counter by one.
- R4: With select active and OE=0, MR=1, CK=0, the address counter is cleared to 0.
- R5: With select active and OE=0, MR=1, CK=1, the counter holds and the bus is not driven.
- R6: With select active and OE=1, MR=0, CK=0, `bus_drive` is 1 and `bus_q` carries the stored byte at the current address modulo DEPTH (default 64).
- R7: With select active and OE=1, MR=1, the bus is not driven, and the counter does not change for any value or transition of CK.
- R8: With select active and OE=1, MR=0, CK=1, the bus is not driven and the counter holds.
- R9: The stored byte at index i is HDR_BASE+i for i below HDR_LEN (defaults 0xC0 and 10), which forms the identification header. For other i it is i[7:0] XOR DATA_KEY (default 0x5A).
- R10: The counter is ADDR_W bits wide (default 16) and wraps from its maximum value to 0 on the next step.
- R11: An input change reaches the outputs on the third rising clock edge after it is sampled, with SYNC_STAGES=2. Whenever `bus_drive` is 0, `bus_q` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel_n | input | 1 | Slot select, active low |
| ctl_oe | input | 1 | Output-enable control line |
| ctl_mr | input | 1 | Master-reset control line |
| ctl_ck | input | 1 | Counter clock control line, both edges count |
| bus_q | output | 8 | Byte presented to the shared bus pad |
| bus_drive | output | 1 | Pad drive enable; 0 means the bus is released |

## Verification
Three step lengths are used: five transitions, so the count ends on a rising CK; twelve transitions, which cross the header into data; and 65536 transitions, which show wrap-around. Each step run is followed by a read, so a miss on either CK edge or an off-by-one shows up as a wrong byte. The remaining codes (hold, latch, read with CK high, and any code while deselected) are each applied with CK toggling between two reads at a known address. A counter that reacts to any of them then returns a different byte. A reference model compares both outputs on every clock, so the three-edge latency and the zero value of the released bus are checked throughout.

// File: rtl/slot_pack_pkg.sv
package slot_pack_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_STEP,
      OP_CLEAR,
      OP_HOLD,
      OP_DRIVE,
      OP_PARK,
      OP_LATCH
   } ctl_op_e;

   function automatic ctl_op_e decode_op(logic sel_n, logic oe, logic mr, logic ck);
      ctl_op_e op;
      if (sel_n)               op = OP_NONE;
      else if (oe && mr)       op = OP_LATCH;
      else if (oe && !ck)      op = OP_DRIVE;
      else if (oe)             op = OP_PARK;
      else if (!mr)            op = OP_STEP;
      else if (!ck)            op = OP_CLEAR;
      else                     op = OP_HOLD;
      return op;
   endfunction

   function automatic logic [7:0] store_init(int idx, int hdr_len,
                                              logic [7:0] base, logic [7:0] key);
      logic [7:0] v;
      if (idx < hdr_len) v = base + 8'(idx);
      else               v = 8'(idx) ^ key;
      return v;
   endfunction

endpackage

// File: rtl/slot_in_sync.sv
module slot_in_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 0 && STAGES <= 4)
      else $error("slot_in_sync: STAGES out of range");

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/slot_addr_ctr.sv
module slot_addr_ctr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              clear,
   output logic [ADDR_W-1:0] addr
);
   initial assert (ADDR_W >= 1 && ADDR_W <= 32)
      else $error("slot_addr_ctr: ADDR_W out of range");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr <= '0;
      else if (clear) addr <= '0;
      else if (step)  addr <= addr + 1'b1;
   end

   assert_step_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear) |=> addr == ADDR_W'($past(addr) + 1'b1));
   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> addr == '0);
   assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(addr));
endmodule

// File: rtl/slot_pack_store.sv
module slot_pack_store
   import slot_pack_pkg::*;
#(
   parameter int         DEPTH    = 64,
   parameter int         HDR_LEN  = 10,
   parameter logic [7:0] HDR_BASE = 8'hC0,
   parameter logic [7:0] DATA_KEY = 8'h5A,
   localparam int        IDX_W    = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       rd_byte
);
   initial assert (DEPTH > HDR_LEN && (DEPTH & (DEPTH - 1)) == 0 && DEPTH <= 1024)
      else $error("slot_pack_store: DEPTH must be a power of two above HDR_LEN");

   logic [7:0] rom [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cell
         assign rom[i] = store_init(i, HDR_LEN, HDR_BASE, DATA_KEY);
      end
   endgenerate

   assign rd_byte = rom[idx];
endmodule

// File: rtl/slot_pack_seq.sv
module slot_pack_seq
   import slot_pack_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         ADDR_W      = 16,
   parameter int         DEPTH       = 64,
   parameter int         HDR_LEN     = 10,
   parameter logic [7:0] HDR_BASE    = 8'hC0,
   parameter logic [7:0] DATA_KEY    = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slot_sel_n,
   input  logic       ctl_oe,
   input  logic       ctl_mr,
   input  logic       ctl_ck,
   output logic [7:0] bus_q,
   output logic       bus_drive
);
   localparam int IDX_W = $clog2(DEPTH);

   initial assert (ADDR_W >= IDX_W)
      else $error("slot_pack_seq: counter narrower than store index");

   logic [3:0] ctl_s;
   logic       ck_prev;
   ctl_op_e    op;
   logic       step, clear, drive;
   logic [ADDR_W-1:0] addr;
   logic [7:0] rd_byte;

   slot_in_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1000)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({slot_sel_n, ctl_oe, ctl_mr, ctl_ck}),
      .q(ctl_s)
   );

   assign op = decode_op(ctl_s[3], ctl_s[2], ctl_s[1], ctl_s[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ck_prev <= 1'b0;
      else        ck_prev <= ctl_s[0];
   end

   assign step  = (op == OP_STEP) && (ctl_s[0] != ck_prev);
   assign clear = (op == OP_CLEAR);
   assign drive = (op == OP_DRIVE);

   slot_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(step), .clear(clear), .addr(addr)
   );

   slot_pack_store #(.DEPTH(DEPTH), .HDR_LEN(HDR_LEN),
                     .HDR_BASE(HDR_BASE), .DATA_KEY(DATA_KEY)) u_store (
      .idx(addr[IDX_W-1:0]), .rd_byte(rd_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_drive <= 1'b0;
         bus_q     <= 8'h00;
      end else begin
         bus_drive <= drive;
         bus_q     <= drive ? rd_byte : 8'h00;
      end
   end

   assert_deselect_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_s[3] |=> !bus_drive);
   assert_deselect_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_s[3] |=> $stable(addr));
   assert_read_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DRIVE) |=> bus_drive);
   assert_latch_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LATCH) |=> (!bus_drive && $stable(addr)));
   assert_park_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PARK) |=> (!bus_drive && $stable(addr)));
   assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (&addr)) |=> addr == '0);
   assert_released_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_drive |-> bus_q == 8'h00);
endmodule

// File: tb/sim_slot_pack_seq.sv
module sim_slot_pack_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_sel_n = 1'b1, ctl_oe = 1'b0, ctl_mr = 1'b0, ctl_ck = 1'b0;
   logic [7:0] bus_q;
   logic       bus_drive;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   slot_pack_seq u0 (
      .clk(clk), .rst_n(rst_n), .slot_sel_n(slot_sel_n),
      .ctl_oe(ctl_oe), .ctl_mr(ctl_mr), .ctl_ck(ctl_ck),
      .bus_q(bus_q), .bus_drive(bus_drive)
   );

   function automatic logic [7:0] ref_byte(int a);
      int i = a % 64;
      if (i < 10) return 8'hC0 + 8'(i);
      return 8'(i) ^ 8'h5A;
   endfunction

   // reference model: inputs take effect two edges after capture
   logic [3:0] hq[$];
   logic       m_prev;
   int         m_addr;
   logic       e_en;
   logic [7:0] e_q;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hq = {4'b1000, 4'b1000};
         m_prev = 1'b0; m_addr = 0; e_en = 1'b0; e_q = 8'h00;
      end else begin
         logic [3:0] u;
         u = hq.pop_front();
         hq.push_back({slot_sel_n, ctl_oe, ctl_mr, ctl_ck});
         e_en = !u[3] && u[2] && !u[1] && !u[0];
         e_q  = e_en ? ref_byte(m_addr) : 8'h00;
         if (!u[3]) begin
            if (!u[2] && !u[1] && (u[0] != m_prev)) m_addr = (m_addr + 1) % 65536;
            else if (!u[2] && u[1] && !u[0])        m_addr = 0;
         end
         m_prev = u[0];
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (bus_drive !== e_en || bus_q !== e_q) begin
            errors++;
            $display("FAIL %s model: drive=%0b q=%02h expected drive=%0b q=%02h",
                     cur_req, bus_drive, bus_q, e_en, e_q);
         end
      end
   end

   task automatic check(string req, logic act_en, logic [7:0] act_q,
                        logic exp_en, logic [7:0] exp_q);
      checks++;
      if (act_en !== exp_en || act_q !== exp_q) begin
         errors++;
         $display("FAIL %s: drive=%0b q=%02h expected drive=%0b q=%02h",
                  req, act_en, act_q, exp_en, exp_q);
      end
   endtask

   task automatic apply(logic s, logic o, logic m, logic c, int n);
      slot_sel_n = s; ctl_oe = o; ctl_mr = m; ctl_ck = c;
      repeat (n) @(negedge clk);
   endtask

   task automatic toggle(int n);
      for (int i = 0; i < n; i++) begin
         ctl_ck = ~ctl_ck;
         @(negedge clk);
      end
   endtask

   task automatic read_expect(string req, logic [7:0] exp);
      apply(1'b0, 1'b1, 1'b0, 1'b0, 3);
      check(req, bus_drive, bus_q, 1'b1, exp);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      check("R1 reset outputs", bus_drive, bus_q, 1'b0, 8'h00);
      read_expect("R1 addr zero after reset", 8'hC0);

      // R11 latency: drive appears on third edge
      cur_req = "R11";
      apply(1'b0, 1'b1, 1'b0, 1'b0, 2);
      check("R11 not yet driven", bus_drive, bus_q, 1'b0, 8'h00);
      @(negedge clk);
      check("R11 driven on third edge", bus_drive, bus_q, 1'b1, 8'hC0);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 3);

      cur_req = "R3";
      toggle(5);
      read_expect("R3 both CK edges count, R9 header", 8'hC5);

      cur_req = "R4";
      apply(1'b0, 1'b0, 1'b1, 1'b0, 2);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 2);
      read_expect("R4 clear", 8'hC0);

      cur_req = "R9";
      toggle(12);
      read_expect("R9 data past header", 8'h56);

      cur_req = "R5";
      apply(1'b0, 1'b0, 1'b1, 1'b1, 4);
      check("R5 hold not driven", bus_drive, bus_q, 1'b0, 8'h00);
      read_expect("R5 hold keeps address", 8'h56);

      cur_req = "R7";
      apply(1'b0, 1'b1, 1'b1, 1'b0, 3);
      toggle(6);
      check("R7 latch not driven", bus_drive, bus_q, 1'b0, 8'h00);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 3);
      read_expect("R7 latch keeps address", 8'h56);

      cur_req = "R8";
      apply(1'b0, 1'b1, 1'b0, 1'b1, 4);
      check("R8 OE with CK high not driven", bus_drive, bus_q, 1'b0, 8'h00);
      read_expect("R8 address held", 8'h56);

      cur_req = "R2";
      apply(1'b1, 1'b0, 1'b1, 1'b0, 3);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 1);
      toggle(7);
      apply(1'b1, 1'b1, 1'b0, 1'b0, 4);
      check("R2 deselected not driven", bus_drive, bus_q, 1'b0, 8'h00);
      apply(1'b1, 1'b0, 1'b0, 1'b0, 3);
      read_expect("R2 deselected codes ignored", 8'h56);

      cur_req = "R10";
      apply(1'b0, 1'b0, 1'b1, 1'b0, 2);
      apply(1'b0, 1'b0, 1'b0, 1'b0, 2);
      toggle(65535);
      read_expect("R10 top address", 8'h65);
      toggle(1);
      read_expect("R10 wraps to zero", 8'hC0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule